// File: doc/BRIEF.md
# Qualified Reset Sequencer With Deglitch

This block turns an asynchronous, active-high external reset pin into a clean internal reset for an 8051-style core. A free-running counter divides the oscillator clock into machine cycles of six states, each state split into two phases (12 clocks per machine cycle). The pin passes through a two-flop synchronizer and is looked at only once per machine cycle, in the second phase of the fifth state. The internal reset asserts only after two consecutive samples have found the pin high. Any low sample clears the qualification count, so pulses shorter than a machine cycle can neither start a reset nor stretch one.

While the internal reset is active, the block holds a small special-function register model at its reset values. Port latches read 0xFF, the stack pointer reads 0x07, and the general SFRs read zero. The power-control register is cleared apart from one bit, which keeps its value. The serial data buffer keeps its contents. A simple write port and a combinational read port reach the register model, so the core, or a bench, can load and observe it. A one-cycle pulse marks the clock in which the internal reset begins.

Top module: `rst_sequencer`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block clears the internal reset and the start pulse. It sets every port register to 0xFF and the stack pointer to 0x07, and it clears power-control, the serial buffer and every general SFR to 0x00.
- R2: The clock that follows the release of `rst_n` is S1P1. A machine cycle is 12 clocks (S1P1, S1P2, ... S6P2). The synchronized pin is sampled only in the S5P2 clock. Counting clock edges with `rst_n` high from 1, `core_rst` changes only on edges whose count is 10 modulo 12.
- R3: `core_rst` asserts at the second of two consecutive high samples. A pin held high for 24 consecutive clocks always asserts it.
- R4: A high pulse of 12 clocks or fewer never asserts `core_rst`. A low sample clears the count, so high 12 / low 12 / high 12 never asserts.
- R5: Once asserted, `core_rst` stays high while the pin stays high. It deasserts at the first sample that finds the pin low.
- R6: `rst_start` is high for exactly one clock, in the first clock in which `core_rst` is high, once per reset.
- R7: While `core_rst` is high, every port register reads 0xFF and the stack pointer reads 0x07.
- R8: While `core_rst` is high, the power-control register reads 0x00 except bit 4, which keeps the value it had before the reset.
- R9: While `core_rst` is high, every general SFR reads 0x00 and the serial buffer keeps its contents.
- R10: Writes are ignored while `core_rst` is high. The address map is: ports at 0 to NUM_PORTS-1, stack pointer at NUM_PORTS, power-control at NUM_PORTS+1, serial buffer at NUM_PORTS+2, and general SFRs from NUM_PORTS+3 upward. With the defaults these are ports 0-3, stack pointer 4, power-control 5, serial buffer 6 and general SFRs 7-10.
- R11: When `core_rst` is low, `wr_en` writes `wr_data` to the addressed register at the clock edge. `rd_data` shows the addressed register combinationally, and 0x00 for an unmapped address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Synchronous active-low power-on reset of the block |
| ext_rst_pin | input | 1 | Asynchronous active-high external reset pin |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW (4) | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | AW (4) | Register read address |
| rd_data | output | 8 | Register read data |
| core_rst | output | 1 | Qualified internal reset, active high |
| rst_start | output | 1 | One-clock pulse at the start of an internal reset |

## Verification
The assertions take `rst_n` to be a clean synchronous reset. They also take the register model to change only through its own write port, so a stable serial buffer or a kept power-control bit during reset reflects the design rather than the stimulus. The external pin may toggle at any time, because the properties look only at its synchronized copy. The bench changes every input on the falling clock edge and holds pin levels for whole clock counts. As a result, the number of S5P2 samples that fall inside a pulse depends only on its width, which lets the glitch and boundary cases be predicted exactly.

// File: rtl/rst_seq_pkg.sv
// Package: shared data type and reset constants of the reset sequencer.
// Assumes 8-bit special-function registers.
package rst_seq_pkg;
    localparam int DATA_W = 8;
    typedef logic [DATA_W-1:0] byte_t;
    localparam byte_t PORT_RST_VAL = 8'hFF;
    localparam byte_t SP_RST_VAL   = 8'h07;
    localparam byte_t CLR_VAL      = 8'h00;
endpackage

// File: rtl/rst_pin_sync.sv
// Module: multi-flop synchronizer for the asynchronous reset pin.
// Assumes STAGES >= 2; the output lags the pin by STAGES clocks.
module rst_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_async,
    output logic pin_sync
);
    logic [STAGES-1:0] chain_q;

    // Shift the pin level through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], pin_async};
    end

    assign pin_sync = chain_q[STAGES-1];
endmodule

// File: rtl/mc_timer.sv
// Module: free-running state/phase counter for machine cycles.
// Produces a one-clock strobe in the configured state and phase.
// Assumes states and phases are numbered from 1; the tick after reset is S1P1.
module mc_timer #(
    parameter int STATES       = 6,
    parameter int PHASES       = 2,
    parameter int SAMPLE_STATE = 5,
    parameter int SAMPLE_PHASE = 2
) (
    input  logic clk,
    input  logic rst_n,
    output logic sample_stb
);
    localparam int TICKS       = STATES * PHASES;
    localparam int TW          = $clog2(TICKS);
    localparam int SAMPLE_TICK = (SAMPLE_STATE - 1) * PHASES + (SAMPLE_PHASE - 1);

    logic [TW-1:0] tick_q;

    // Advance the tick and wrap at the end of each machine cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)                         tick_q <= '0;
        else if (tick_q == TW'(TICKS - 1))  tick_q <= '0;
        else                                tick_q <= tick_q + TW'(1);
    end

    // Decode the sampling slot.
    assign sample_stb = (tick_q == TW'(SAMPLE_TICK));
endmodule

// File: rtl/rst_qualifier.sv
// Module: counts consecutive high samples of the synchronized pin.
// Raises the internal reset after QUAL_SAMPLES of them.
// Assumes samples are taken only on sample_stb; any low sample clears the count and ends an active reset.
module rst_qualifier #(
    parameter int QUAL_SAMPLES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sample_stb,
    input  logic pin_sync,
    output logic core_rst,
    output logic rst_start
);
    localparam int CW = $clog2(QUAL_SAMPLES + 1);

    logic [CW-1:0] hits_q;

    // Update the saturating count, the reset state and the start pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hits_q    <= '0;
            core_rst  <= 1'b0;
            rst_start <= 1'b0;
        end else begin
            rst_start <= 1'b0;
            if (sample_stb) begin
                if (pin_sync) begin
                    if (hits_q != CW'(QUAL_SAMPLES)) hits_q <= hits_q + CW'(1);
                    if (!core_rst && hits_q == CW'(QUAL_SAMPLES - 1)) begin
                        core_rst  <= 1'b1;
                        rst_start <= 1'b1;
                    end
                end else begin
                    hits_q   <= '0;
                    core_rst <= 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/sfr_reset_model.sv
// Module: small special-function register file.
// Holds the reset values while core_rst is high: ports 0xFF, stack pointer 0x07, general SFRs 0x00,
// power-control cleared except KEEP_BIT, serial buffer untouched.
// Assumes writes arrive on a single write port and are dropped during reset.
module sfr_reset_model
    import rst_seq_pkg::*;
#(
    parameter int NUM_PORTS = 4,
    parameter int NUM_GEN   = 4,
    parameter int KEEP_BIT  = 4,
    parameter int AW        = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          core_rst,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  byte_t         wr_data,
    output byte_t         port_q [NUM_PORTS],
    output byte_t         sp_q,
    output byte_t         pcon_q,
    output byte_t         sbuf_q,
    output byte_t         gen_q  [NUM_GEN]
);
    localparam int    ADR_SP    = NUM_PORTS;
    localparam int    ADR_PCON  = NUM_PORTS + 1;
    localparam int    ADR_SBUF  = NUM_PORTS + 2;
    localparam int    ADR_GEN0  = NUM_PORTS + 3;
    localparam byte_t KEEP_MASK = byte_t'(1) << KEEP_BIT;

    logic wr_ok;
    assign wr_ok = wr_en && !core_rst;

    for (genvar i = 0; i < NUM_PORTS; i++) begin : g_port
        // Port latch: forced high during reset, else written.
        always_ff @(posedge clk) begin
            if (!rst_n || core_rst)                   port_q[i] <= PORT_RST_VAL;
            else if (wr_ok && wr_addr == AW'(i))      port_q[i] <= wr_data;
        end
    end

    for (genvar g = 0; g < NUM_GEN; g++) begin : g_gen
        // General SFR: cleared during reset, else written.
        always_ff @(posedge clk) begin
            if (!rst_n || core_rst)                       gen_q[g] <= CLR_VAL;
            else if (wr_ok && wr_addr == AW'(ADR_GEN0 + g)) gen_q[g] <= wr_data;
        end
    end

    // Stack pointer: loaded with its reset value during reset.
    always_ff @(posedge clk) begin
        if (!rst_n || core_rst)                    sp_q <= SP_RST_VAL;
        else if (wr_ok && wr_addr == AW'(ADR_SP))  sp_q <= wr_data;
    end

    // Power-control: cleared at power-on, all but the kept bit cleared during reset.
    always_ff @(posedge clk) begin
        if (!rst_n)                                  pcon_q <= CLR_VAL;
        else if (core_rst)                           pcon_q <= pcon_q & KEEP_MASK;
        else if (wr_ok && wr_addr == AW'(ADR_PCON))  pcon_q <= wr_data;
    end

    // Serial buffer: cleared only at power-on, never by the internal reset.
    always_ff @(posedge clk) begin
        if (!rst_n)                                  sbuf_q <= CLR_VAL;
        else if (wr_ok && wr_addr == AW'(ADR_SBUF))  sbuf_q <= wr_data;
    end
endmodule

// File: rtl/rst_sequencer.sv
// Module: top of the qualified reset sequencer.
// Chains the pin synchronizer, machine-cycle timer and qualifier, applies the reset values
// to the register model, and provides a combinational read mux.
// Assumes rst_n is synchronous to clk; ext_rst_pin may be fully asynchronous.
module rst_sequencer
    import rst_seq_pkg::*;
#(
    parameter int  STATES       = 6,
    parameter int  PHASES       = 2,
    parameter int  SAMPLE_STATE = 5,
    parameter int  SAMPLE_PHASE = 2,
    parameter int  QUAL_SAMPLES = 2,
    parameter int  SYNC_STAGES  = 2,
    parameter int  NUM_PORTS    = 4,
    parameter int  NUM_GEN      = 4,
    parameter int  KEEP_BIT     = 4,
    localparam int NUM_REGS     = NUM_PORTS + 3 + NUM_GEN,
    localparam int AW           = $clog2(NUM_REGS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ext_rst_pin,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [7:0]    wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [7:0]    rd_data,
    output logic          core_rst,
    output logic          rst_start
);
    localparam int ADR_SP   = NUM_PORTS;
    localparam int ADR_PCON = NUM_PORTS + 1;
    localparam int ADR_SBUF = NUM_PORTS + 2;
    localparam int ADR_GEN0 = NUM_PORTS + 3;

    logic  pin_sync;
    logic  smp_stb;
    byte_t port_q [NUM_PORTS];
    byte_t gen_q  [NUM_GEN];
    byte_t sp_q, pcon_q, sbuf_q;

    rst_pin_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk(clk), .rst_n(rst_n), .pin_async(ext_rst_pin), .pin_sync(pin_sync)
    );

    mc_timer #(
        .STATES(STATES), .PHASES(PHASES),
        .SAMPLE_STATE(SAMPLE_STATE), .SAMPLE_PHASE(SAMPLE_PHASE)
    ) i_timer (
        .clk(clk), .rst_n(rst_n), .sample_stb(smp_stb)
    );

    rst_qualifier #(.QUAL_SAMPLES(QUAL_SAMPLES)) i_qual (
        .clk(clk), .rst_n(rst_n), .sample_stb(smp_stb), .pin_sync(pin_sync),
        .core_rst(core_rst), .rst_start(rst_start)
    );

    sfr_reset_model #(
        .NUM_PORTS(NUM_PORTS), .NUM_GEN(NUM_GEN), .KEEP_BIT(KEEP_BIT), .AW(AW)
    ) i_sfr (
        .clk(clk), .rst_n(rst_n), .core_rst(core_rst),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .port_q(port_q), .sp_q(sp_q), .pcon_q(pcon_q), .sbuf_q(sbuf_q), .gen_q(gen_q)
    );

    // Select the addressed register; unmapped addresses read zero.
    always_comb begin
        rd_data = CLR_VAL;
        for (int i = 0; i < NUM_PORTS; i++)
            if (rd_addr == AW'(i)) rd_data = port_q[i];
        for (int g = 0; g < NUM_GEN; g++)
            if (rd_addr == AW'(ADR_GEN0 + g)) rd_data = gen_q[g];
        if (rd_addr == AW'(ADR_SP))   rd_data = sp_q;
        if (rd_addr == AW'(ADR_PCON)) rd_data = pcon_q;
        if (rd_addr == AW'(ADR_SBUF)) rd_data = sbuf_q;
    end
endmodule

// File: rtl/rst_seq_chk.sv
// Module: property checker for the reset sequencer, attached by bind.
// Assumes the register model changes only through its own write port.
module rst_seq_chk #(
    parameter int KEEP_BIT = 4
) (
    input logic       clk,
    input logic       rst_n,
    input logic       smp_stb,
    input logic       pin_sync,
    input logic       core_rst,
    input logic       rst_start,
    input logic [7:0] sp_q,
    input logic [7:0] pcon_q,
    input logic [7:0] sbuf_q,
    input logic [7:0] port0_q
);
    localparam logic [7:0] OTHER_MASK = ~(8'd1 << KEEP_BIT);

    p_change_on_sample_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(core_rst) |-> $past(smp_stb));

    p_rise_needs_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(core_rst) |-> $past(pin_sync));

    p_fall_needs_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(core_rst) |-> !$past(pin_sync));

    p_start_with_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rst_start |-> $rose(core_rst));

    p_start_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rst_start |=> !rst_start);

    p_port_sp_values_r7: assert property (@(posedge clk) disable iff (!rst_n)
        core_rst |=> (sp_q == 8'h07 && port0_q == 8'hFF));

    p_pcon_keep_bit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        core_rst |=> (pcon_q[KEEP_BIT] == $past(pcon_q[KEEP_BIT]) && (pcon_q & OTHER_MASK) == 8'h00));

    p_sbuf_kept_r9: assert property (@(posedge clk) disable iff (!rst_n)
        core_rst |=> $stable(sbuf_q));
endmodule

bind rst_sequencer rst_seq_chk #(.KEEP_BIT(KEEP_BIT)) i_chk (
    .clk(clk), .rst_n(rst_n), .smp_stb(smp_stb), .pin_sync(pin_sync),
    .core_rst(core_rst), .rst_start(rst_start),
    .sp_q(sp_q), .pcon_q(pcon_q), .sbuf_q(sbuf_q), .port0_q(port_q[0])
);

// File: tb/test_rst_sequencer.sv
// Bench: directed scenarios for the reset sequencer, one task each.
module test_rst_sequencer;
    localparam int AW = 4;
    localparam int A_SP = 4, A_PCON = 5, A_SBUF = 6, A_GEN0 = 7;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ext_rst_pin = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [7:0]    wr_data = '0;
    logic [AW-1:0] rd_addr = '0;
    logic [7:0]    rd_data;
    logic          core_rst;
    logic          rst_start;

    int checks = 0;
    int errors = 0;
    int ecount = 0;
    int pulse_cnt = 0;
    bit seen_rst = 1'b0;
    bit prev_rst = 1'b0;
    bit prev_start = 1'b0;
    bit done = 1'b0;

    rst_sequencer i_rst_sequencer (
        .clk(clk), .rst_n(rst_n), .ext_rst_pin(ext_rst_pin),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .core_rst(core_rst), .rst_start(rst_start)
    );

    always #5 clk = ~clk;

    // Count clock edges seen with rst_n high.
    always @(posedge clk) if (rst_n) ecount <= ecount + 1;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Monitor: edge timing of core_rst (R2) and width of rst_start (R6).
    always @(negedge clk) begin
        if (rst_n) begin
            if (core_rst !== prev_rst)
                check((ecount % 12) == 10, "R2", "core_rst change slot", ecount % 12, 10);
            if (rst_start && prev_start)
                check(1'b0, "R6", "start pulse longer than one clock", 2, 1);
            if (rst_start)
                check(core_rst === 1'b1, "R6", "core_rst with start pulse", core_rst, 1);
            if (rst_start) pulse_cnt++;
            if (core_rst) seen_rst = 1'b1;
            prev_rst   = core_rst;
            prev_start = rst_start;
        end
    end

    task automatic wait_clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input int a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = AW'(a); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input int a, output logic [7:0] d);
        rd_addr = AW'(a);
        #1 d = rd_data;
    endtask

    task automatic expect_reg(input int a, input logic [7:0] exp, input string req);
        logic [7:0] v;
        rd(a, v);
        check(v === exp, req, $sformatf("register %0d", a), v, exp);
    endtask

    task automatic pulse(input int hi);
        @(negedge clk); ext_rst_pin = 1'b1;
        wait_clks(hi);
        ext_rst_pin = 1'b0;
    endtask

    // R1: values after power-on reset.
    task automatic t_power_on;
        check(core_rst === 1'b0, "R1", "core_rst after power-on", core_rst, 0);
        check(rst_start === 1'b0, "R1", "rst_start after power-on", rst_start, 0);
        for (int p = 0; p < 4; p++) expect_reg(p, 8'hFF, "R1");
        expect_reg(A_SP, 8'h07, "R1");
        expect_reg(A_PCON, 8'h00, "R1");
        expect_reg(A_SBUF, 8'h00, "R1");
        for (int g = 0; g < 4; g++) expect_reg(A_GEN0 + g, 8'h00, "R1");
        expect_reg(15, 8'h00, "R11");
    endtask

    // R4: short pulses and an interrupted pair never qualify.
    task automatic t_glitches;
        seen_rst = 1'b0;
        pulse(3);  wait_clks(30);
        check(!seen_rst, "R4", "3-clock glitch asserted reset", seen_rst, 0);
        pulse(12); wait_clks(30);
        check(!seen_rst, "R4", "12-clock pulse asserted reset", seen_rst, 0);
        pulse(12); wait_clks(12);
        pulse(12); wait_clks(30);
        check(!seen_rst, "R4", "high/low/high asserted reset", seen_rst, 0);
    endtask

    // Load the registers with known values through the write port (R11).
    task automatic load_regs(input logic [7:0] pcon_v);
        for (int p = 0; p < 4; p++) wr(p, 8'h12 + 8'(p));
        wr(A_SP, 8'h55);
        wr(A_PCON, pcon_v);
        wr(A_SBUF, 8'hA5);
        for (int g = 0; g < 4; g++) wr(A_GEN0 + g, 8'h3C);
        @(negedge clk);
        expect_reg(1, 8'h13, "R11");
        expect_reg(A_SP, 8'h55, "R11");
        expect_reg(A_PCON, pcon_v, "R11");
        expect_reg(A_GEN0 + 2, 8'h3C, "R11");
    endtask

    // Check the register values held during reset (R7, R8, R9).
    task automatic expect_reset_vals(input logic [7:0] pcon_exp);
        for (int p = 0; p < 4; p++) expect_reg(p, 8'hFF, "R7");
        expect_reg(A_SP, 8'h07, "R7");
        expect_reg(A_PCON, pcon_exp, "R8");
        expect_reg(A_SBUF, 8'hA5, "R9");
        for (int g = 0; g < 4; g++) expect_reg(A_GEN0 + g, 8'h00, "R9");
    endtask

    // R3, R5, R6, R7-R10: a long reset with power-control bit 4 set.
    task automatic t_long_reset;
        load_regs(8'hFF);
        pulse_cnt = 0;
        @(negedge clk); ext_rst_pin = 1'b1;
        wait_clks(40);
        check(core_rst === 1'b1, "R3", "core_rst after 40 high clocks", core_rst, 1);
        expect_reset_vals(8'h10);
        wr(0, 8'h00); wr(A_SBUF, 8'h11); wr(A_GEN0, 8'h77);
        expect_reg(0, 8'hFF, "R10");
        expect_reg(A_SBUF, 8'hA5, "R10");
        expect_reg(A_GEN0, 8'h00, "R10");
        wait_clks(36);
        check(core_rst === 1'b1, "R5", "core_rst while pin held", core_rst, 1);
        ext_rst_pin = 1'b0;
        wait_clks(20);
        check(core_rst === 1'b0, "R5", "core_rst after pin low", core_rst, 0);
        check(pulse_cnt == 1, "R6", "start pulses per reset", pulse_cnt, 1);
        wr(A_GEN0, 8'h77);
        expect_reg(A_GEN0, 8'h77, "R11");
    endtask

    // R3, R8: exactly 24 high clocks qualify; power-control bit 4 clear stays clear.
    task automatic t_boundary;
        load_regs(8'hEF);
        seen_rst = 1'b0;
        pulse_cnt = 0;
        pulse(24);
        wait_clks(2);
        check(seen_rst, "R3", "24-clock pulse asserted reset", seen_rst, 1);
        expect_reset_vals(8'h00);
        wait_clks(20);
        check(core_rst === 1'b0, "R5", "core_rst after 24-clock pulse", core_rst, 0);
        check(pulse_cnt == 1, "R6", "start pulses for 24-clock pulse", pulse_cnt, 1);
    endtask

    initial begin
        wait_clks(4);
        t_power_on;
        rst_n = 1'b1;
        wait_clks(3);
        t_power_on;
        t_glitches;
        t_long_reset;
        t_boundary;
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=0", 1);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule